// File: doc/BRIEF.md
# Alert Class Escalation Controller

This block runs the escalation policy for one alert class. Classified alert triggers for the class come in each cycle. They are merged into a single event and counted in a saturating accumulator. When an event arrives while the count has already reached a programmed threshold, the class escalates. A second path escalates the class when its interrupt stays pending for longer than a programmed timeout. Both the timeout and the escalation phases are timed by one shared cycle counter.

Once escalation starts, the controller moves through four phases. Each phase has its own programmed length. The controller then enters a terminal state and stays there. Each of the four escalation outputs has an enable bit and a phase selector, so an output can fire in any phase. A clear request returns the class to idle. If the lock bit was set when escalation began, clear requests are refused until reset.

A snapshot port carries the state, the accumulator and the counter. It follows the live values until escalation first begins and then holds the values seen at that moment. This lets debug logic read the cause even after countermeasures have disturbed the rest of the system.

Top module: `esc_class_ctrl`

## Requirements
- R1: While en_i is high, a cycle with one or more trig_i bits high adds exactly one to accum_cnt_o at the next clock edge, however many bits are set.
- R2: accum_cnt_o is 16 bits wide. It saturates at 0xFFFF and never wraps.
- R3: A merged trigger in a cycle where accum_cnt_o >= accum_thresh_i starts escalation, and state_o is Phase0 after the next edge. A threshold of 15 fires on the 16th trigger; a threshold of 0 fires on the first.
- R4: In Idle, with en_i and irq_pend_i high and timeout_cyc_i = T != 0, the next state is Timeout with esc_cnt_o = 1. The counter then increments each cycle, and Phase0 is reached T+1 edges after irq_pend_i was first sampled. A trigger that meets the threshold while in Timeout escalates at once.
- R5: Dropping irq_pend_i in Timeout returns the class to Idle with esc_cnt_o = 0 on the next edge. With T = 0, the timeout path never leaves Idle.
- R6: State codes on state_o: Idle 3'b000, Timeout 3'b001, Terminal 3'b011, and Phase0 to Phase3 3'b100 to 3'b111. Phase k lasts phase_cyc_i[k]+1 cycles, with esc_cnt_o counting from 0. Phase3 is followed by Terminal, which holds until a permitted clear. Reset gives Idle with both counters at 0.
- R7: esc_o[i] is high exactly when esc_en_i[i] is high and state_o is Phase k with k equal to esc_map_i[i]. Field i occupies bits [2i+1:2i] of the map.
- R8: A permitted clr_i returns the class to Idle with both counters at 0 on the next edge. The clear wins over a trigger in the same cycle.
- R9: If lock_i is high in the cycle escalation starts, every later clr_i is ignored until reset.
- R10: With en_i low, triggers are not counted and the state does not leave Idle.
- R11: snap_state_o, snap_accum_o and snap_cnt_o equal the live values up to and including the first cycle in Phase0. From then on they hold those values, with snap_frozen_o high, until a permitted clear releases them on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Class enable |
| lock_i | input | 1 | Makes escalation non-clearable once started |
| trig_i | input | NTrig | Classified alert triggers of this cycle |
| irq_pend_i | input | 1 | Class interrupt pending level |
| clr_i | input | 1 | Clear request |
| accum_thresh_i | input | AccW | Accumulation threshold |
| timeout_cyc_i | input | CntW | Interrupt timeout in cycles, 0 disables |
| phase_cyc_i | input | 4*CntW | Per-phase cycle counts, phase k in slice k |
| esc_en_i | input | NumEsc | Per-output enable |
| esc_map_i | input | 2*NumEsc | Per-output phase selector |
| esc_o | output | NumEsc | Escalation requests |
| state_o | output | 3 | Class state code |
| accum_cnt_o | output | AccW | Accumulator value |
| esc_cnt_o | output | CntW | Shared cycle counter value |
| snap_state_o | output | 3 | Snapshot of the state |
| snap_accum_o | output | AccW | Snapshot of the accumulator |
| snap_cnt_o | output | CntW | Snapshot of the cycle counter |
| snap_frozen_o | output | 1 | Snapshot is held |

## Verification
A wrong state register shows on state_o and on the decoded esc_o in the same cycle. A bad counter shows one edge later, as a phase or timeout that ends too early or too late. A stuck or wrapped accumulator shows as an escalation one trigger early or late, or as a count that leaves 0xFFFF. A lost lock bit shows on the first refused clear: the state returns to Idle when it should not. The bench runs a cycle model in step with the block. It compares every output after every edge, so a divergence is reported in the cycle it first appears at the ports.

// File: rtl/esc_class_pkg.sv
package esc_class_pkg;
  localparam int unsigned NumPhases = 4;
  localparam int unsigned PhW       = $clog2(NumPhases);
  localparam int unsigned StW       = 3;

  // bit 2 marks an escalation phase, bits 1:0 give its index
  typedef enum logic [StW-1:0] {
    StIdle     = 3'b000,
    StTimeout  = 3'b001,
    StTerminal = 3'b011,
    StPhase0   = 3'b100,
    StPhase1   = 3'b101,
    StPhase2   = 3'b110,
    StPhase3   = 3'b111
  } esc_state_e;
endpackage

// File: rtl/esc_accum.sv
module esc_accum #(
  parameter int unsigned AccW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            clr_i,
  input  logic [AccW-1:0] thresh_i,
  output logic [AccW-1:0] cnt_o,
  output logic            hit_o
);
  localparam logic [AccW-1:0] CntMax = '1;

  logic [AccW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && (cnt_q != CntMax))  cnt_q <= cnt_q + 1'b1;
  end

  // compare against the count before this event is added
  assign hit_o = inc_i && (cnt_q >= thresh_i);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm import esc_class_pkg::*; #(
  parameter int unsigned CntW = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            lock_i,
  input  logic                            clr_i,
  input  logic                            irq_pend_i,
  input  logic                            acc_hit_i,
  input  logic [CntW-1:0]                 timeout_cyc_i,
  input  logic [NumPhases-1:0][CntW-1:0]  phase_cyc_i,
  output esc_state_e                      state_o,
  output logic [CntW-1:0]                 cnt_o,
  output logic                            clr_ok_o,
  output logic                            lock_o
);
  esc_state_e      state_q, state_d;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic            lock_q, lock_d;
  logic            start;
  logic            clr_ok;

  assign clr_ok = clr_i && !lock_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start   = 1'b0;
    unique case (state_q)
      StIdle: begin
        if (acc_hit_i) begin
          start = 1'b1;
        end else if (en_i && irq_pend_i && (timeout_cyc_i != '0)) begin
          state_d = StTimeout;
          cnt_d   = CntW'(1);
        end
      end
      StTimeout: begin
        if (acc_hit_i) begin
          start = 1'b1;
        end else if (!irq_pend_i) begin
          state_d = StIdle;
          cnt_d   = '0;
        end else if (cnt_q >= timeout_cyc_i) begin
          start = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      StTerminal: begin
        cnt_d = '0;
      end
      default: begin
        if (cnt_q >= phase_cyc_i[state_q[PhW-1:0]]) begin
          cnt_d   = '0;
          state_d = (state_q == StPhase3) ? StTerminal
                                          : esc_state_e'(state_q + 3'd1);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
    if (start) begin
      state_d = StPhase0;
      cnt_d   = '0;
    end
    if (clr_ok) begin
      state_d = StIdle;
      cnt_d   = '0;
    end
  end

  assign lock_d = lock_q || (start && lock_i && !clr_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= StIdle;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lock_q  <= lock_d;
    end
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign clr_ok_o = clr_ok;
  assign lock_o   = lock_q;
endmodule

// File: rtl/esc_out_map.sv
module esc_out_map import esc_class_pkg::*; #(
  parameter int unsigned NumEsc = 4
) (
  input  esc_state_e                  state_i,
  input  logic [NumEsc-1:0]           en_i,
  input  logic [NumEsc-1:0][PhW-1:0]  map_i,
  output logic [NumEsc-1:0]           esc_o
);
  logic in_phase;
  assign in_phase = state_i[StW-1];

  for (genvar g = 0; g < NumEsc; g++) begin : g_out
    assign esc_o[g] = en_i[g] && in_phase && (state_i[PhW-1:0] == map_i[g]);
  end
endmodule

// File: rtl/esc_snap.sv
module esc_snap import esc_class_pkg::*; #(
  parameter int unsigned AccW = 16,
  parameter int unsigned CntW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_ok_i,
  input  esc_state_e      state_i,
  input  logic [AccW-1:0] acc_i,
  input  logic [CntW-1:0] cnt_i,
  output logic [StW-1:0]  snap_state_o,
  output logic [AccW-1:0] snap_acc_o,
  output logic [CntW-1:0] snap_cnt_o,
  output logic            frozen_o
);
  logic            frozen_q;
  logic [StW-1:0]  state_h;
  logic [AccW-1:0] acc_h;
  logic [CntW-1:0] cnt_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      state_h  <= '0;
      acc_h    <= '0;
      cnt_h    <= '0;
    end else if (clr_ok_i) begin
      frozen_q <= 1'b0;
    end else if (!frozen_q && (state_i == StPhase0)) begin
      frozen_q <= 1'b1;
      state_h  <= state_i;
      acc_h    <= acc_i;
      cnt_h    <= cnt_i;
    end
  end

  assign snap_state_o = frozen_q ? state_h : state_i;
  assign snap_acc_o   = frozen_q ? acc_h   : acc_i;
  assign snap_cnt_o   = frozen_q ? cnt_h   : cnt_i;
  assign frozen_o     = frozen_q;
endmodule

// File: rtl/esc_class_ctrl.sv
module esc_class_ctrl import esc_class_pkg::*; #(
  parameter int unsigned NTrig  = 4,
  parameter int unsigned AccW   = 16,
  parameter int unsigned CntW   = 32,
  parameter int unsigned NumEsc = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            lock_i,
  input  logic [NTrig-1:0]                trig_i,
  input  logic                            irq_pend_i,
  input  logic                            clr_i,
  input  logic [AccW-1:0]                 accum_thresh_i,
  input  logic [CntW-1:0]                 timeout_cyc_i,
  input  logic [NumPhases-1:0][CntW-1:0]  phase_cyc_i,
  input  logic [NumEsc-1:0]               esc_en_i,
  input  logic [NumEsc-1:0][PhW-1:0]      esc_map_i,
  output logic [NumEsc-1:0]               esc_o,
  output logic [StW-1:0]                  state_o,
  output logic [AccW-1:0]                 accum_cnt_o,
  output logic [CntW-1:0]                 esc_cnt_o,
  output logic [StW-1:0]                  snap_state_o,
  output logic [AccW-1:0]                 snap_accum_o,
  output logic [CntW-1:0]                 snap_cnt_o,
  output logic                            snap_frozen_o
);
  logic            inc;
  logic            acc_hit;
  logic            clr_ok;
  logic            clr_lock;
  esc_state_e      state;
  logic [AccW-1:0] acc_cnt;
  logic [CntW-1:0] cyc_cnt;

  assign inc = en_i && (|trig_i);

  esc_accum #(.AccW(AccW)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .clr_i    (clr_ok),
    .thresh_i (accum_thresh_i),
    .cnt_o    (acc_cnt),
    .hit_o    (acc_hit)
  );

  esc_fsm #(.CntW(CntW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .lock_i        (lock_i),
    .clr_i         (clr_i),
    .irq_pend_i    (irq_pend_i),
    .acc_hit_i     (acc_hit),
    .timeout_cyc_i (timeout_cyc_i),
    .phase_cyc_i   (phase_cyc_i),
    .state_o       (state),
    .cnt_o         (cyc_cnt),
    .clr_ok_o      (clr_ok),
    .lock_o        (clr_lock)
  );

  esc_out_map #(.NumEsc(NumEsc)) u_map (
    .state_i (state),
    .en_i    (esc_en_i),
    .map_i   (esc_map_i),
    .esc_o   (esc_o)
  );

  esc_snap #(.AccW(AccW), .CntW(CntW)) u_snap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_ok_i     (clr_ok),
    .state_i      (state),
    .acc_i        (acc_cnt),
    .cnt_i        (cyc_cnt),
    .snap_state_o (snap_state_o),
    .snap_acc_o   (snap_accum_o),
    .snap_cnt_o   (snap_cnt_o),
    .frozen_o     (snap_frozen_o)
  );

  assign state_o     = state;
  assign accum_cnt_o = acc_cnt;
  assign esc_cnt_o   = cyc_cnt;
endmodule

// File: rtl/esc_class_chk.sv
module esc_class_chk import esc_class_pkg::*; #(
  parameter int unsigned NTrig  = 4,
  parameter int unsigned AccW   = 16,
  parameter int unsigned NumEsc = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [NTrig-1:0]  trig_i,
  input logic              clr_i,
  input logic [AccW-1:0]   accum_thresh_i,
  input logic [StW-1:0]    state_o,
  input logic [AccW-1:0]   accum_cnt_o,
  input logic [NumEsc-1:0] esc_o,
  input logic [StW-1:0]    snap_state_o,
  input logic              snap_frozen_o,
  input logic              clr_lock_i
);
  localparam logic [AccW-1:0] AccMax = '1;

  logic clr_ok;
  logic fire;
  logic armed;
  assign clr_ok = clr_i && !clr_lock_i;
  assign fire   = en_i && (|trig_i) && (accum_cnt_o >= accum_thresh_i);
  assign armed  = (state_o == StIdle) || (state_o == StTimeout);

  // R2
  a_r2_acc_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accum_cnt_o == AccMax) && !clr_ok |=> accum_cnt_o == AccMax);

  // R3
  a_r3_fire_phase0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && fire && !clr_ok |=> state_o == StPhase0);

  // R6
  a_r6_terminal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == StTerminal) && !clr_ok |=> state_o == StTerminal);

  // R7
  a_r7_out_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_o != '0) |-> state_o[StW-1]);

  // R8
  a_r8_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok |=> (state_o == StIdle) && (accum_cnt_o == '0));

  // R9
  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lock_i |=> clr_lock_i);

  // R10
  a_r10_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == StIdle) && !en_i |=> state_o == StIdle);

  // R11
  a_r11_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_frozen_o && !clr_ok |=> snap_frozen_o && $stable(snap_state_o));
endmodule

bind esc_class_ctrl esc_class_chk #(
  .NTrig  (NTrig),
  .AccW   (AccW),
  .NumEsc (NumEsc)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .trig_i         (trig_i),
  .clr_i          (clr_i),
  .accum_thresh_i (accum_thresh_i),
  .state_o        (state_o),
  .accum_cnt_o    (accum_cnt_o),
  .esc_o          (esc_o),
  .snap_state_o   (snap_state_o),
  .snap_frozen_o  (snap_frozen_o),
  .clr_lock_i     (clr_lock)
);

// File: tb/sim_esc_class_ctrl.sv
module sim_esc_class_ctrl;
  localparam int CLK_PERIOD = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             en_i, lock_i, irq_pend_i, clr_i;
  logic [3:0]       trig_i;
  logic [15:0]      accum_thresh_i;
  logic [31:0]      timeout_cyc_i;
  logic [3:0][31:0] phase_cyc_i;
  logic [3:0]       esc_en_i;
  logic [3:0][1:0]  esc_map_i;
  logic [3:0]       esc_o;
  logic [2:0]       state_o, snap_state_o;
  logic [15:0]      accum_cnt_o, snap_accum_o;
  logic [31:0]      esc_cnt_o, snap_cnt_o;
  logic             snap_frozen_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [2:0]  m_state, h_state;
  logic [15:0] m_acc, h_acc;
  logic [31:0] m_cnt, h_cnt;
  logic        m_lock, m_frz;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  esc_class_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .lock_i(lock_i),
    .trig_i(trig_i), .irq_pend_i(irq_pend_i), .clr_i(clr_i),
    .accum_thresh_i(accum_thresh_i), .timeout_cyc_i(timeout_cyc_i),
    .phase_cyc_i(phase_cyc_i), .esc_en_i(esc_en_i), .esc_map_i(esc_map_i),
    .esc_o(esc_o), .state_o(state_o), .accum_cnt_o(accum_cnt_o),
    .esc_cnt_o(esc_cnt_o), .snap_state_o(snap_state_o),
    .snap_accum_o(snap_accum_o), .snap_cnt_o(snap_cnt_o),
    .snap_frozen_o(snap_frozen_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_esc(input logic [2:0] st);
    logic [3:0] r = '0;
    for (int i = 0; i < 4; i++)
      r[i] = esc_en_i[i] && st[2] && (st[1:0] == esc_map_i[i]);
    return r;
  endfunction

  task automatic model_tick();
    logic cok, inc, hit, start;
    logic [2:0] ns;
    logic [31:0] nc;
    cok = clr_i && !m_lock;
    inc = en_i && (trig_i != 0);
    hit = inc && (m_acc >= accum_thresh_i);
    if (cok) m_frz = 1'b0;
    else if (!m_frz && m_state == 3'b100) begin
      m_frz = 1'b1; h_state = m_state; h_acc = m_acc; h_cnt = m_cnt;
    end
    ns = m_state; nc = m_cnt; start = 1'b0;
    case (m_state)
      3'b000: if (hit) start = 1'b1;
              else if (en_i && irq_pend_i && timeout_cyc_i != 0) begin ns = 3'b001; nc = 1; end
      3'b001: if (hit) start = 1'b1;
              else if (!irq_pend_i) begin ns = 3'b000; nc = 0; end
              else if (m_cnt >= timeout_cyc_i) start = 1'b1;
              else nc = m_cnt + 1;
      3'b011: nc = 0;
      default: if (m_cnt >= phase_cyc_i[m_state[1:0]]) begin
                 nc = 0; ns = (m_state == 3'b111) ? 3'b011 : m_state + 3'd1;
               end else nc = m_cnt + 1;
    endcase
    if (start) begin ns = 3'b100; nc = 0; end
    if (cok) begin ns = 3'b000; nc = 0; end
    if (start && !cok && lock_i) m_lock = 1'b1;
    if (cok) m_acc = 0;
    else if (inc && m_acc != 16'hFFFF) m_acc = m_acc + 1;
    m_state = ns; m_cnt = nc;
  endtask

  task automatic compare();
    chk("R6 state", 32'(state_o), 32'(m_state));
    chk("R2 accum", 32'(accum_cnt_o), 32'(m_acc));
    chk("R4 counter", esc_cnt_o, m_cnt);
    chk("R7 outputs", 32'(esc_o), 32'(exp_esc(m_state)));
    chk("R11 frozen", 32'(snap_frozen_o), 32'(m_frz));
    chk("R11 snap state", 32'(snap_state_o), 32'(m_frz ? h_state : m_state));
    chk("R11 snap accum", 32'(snap_accum_o), 32'(m_frz ? h_acc : m_acc));
    chk("R11 snap cnt", snap_cnt_o, m_frz ? h_cnt : m_cnt);
  endtask

  task automatic step();
    @(posedge clk_i);
    model_tick();
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_state = 0; m_acc = 0; m_cnt = 0; m_lock = 0; m_frz = 0;
    h_state = 0; h_acc = 0; h_cnt = 0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic count_in(input logic [2:0] s, output int n);
    n = 0;
    while (state_o == s && n < 1000) begin n++; step(); end
  endtask

  task automatic defaults();
    en_i = 1; lock_i = 0; irq_pend_i = 0; clr_i = 0; trig_i = 0;
    accum_thresh_i = 0; timeout_cyc_i = 0; phase_cyc_i = '0;
    esc_en_i = 4'hF;
    for (int i = 0; i < 4; i++) esc_map_i[i] = 2'(i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    defaults();
    do_reset();
    chk("R6 reset state", 32'(state_o), 0);
    chk("R6 reset accum", 32'(accum_cnt_o), 0);
    chk("R6 reset counter", esc_cnt_o, 0);
    chk("R7 reset outputs", 32'(esc_o), 0);

    // R1 / R3: threshold 15 fires on the 16th merged trigger
    accum_thresh_i = 15;
    phase_cyc_i[0] = 2; phase_cyc_i[1] = 0; phase_cyc_i[2] = 1; phase_cyc_i[3] = 3;
    for (int k = 0; k < 15; k++) begin
      trig_i = (k % 3 == 0) ? 4'b1011 : 4'b0001;
      step();
    end
    trig_i = 0;
    chk("R1 merged count", 32'(accum_cnt_o), 15);
    chk("R3 no fire at 15", 32'(state_o), 0);
    trig_i = 4'b0100; step(); trig_i = 0;
    chk("R3 fire on 16th", 32'(state_o), 32'h4);
    chk("R7 default map phase0", 32'(esc_o), 32'h1);
    count_in(3'b100, n); chk("R6 phase0 length", n, 3);
    count_in(3'b101, n); chk("R6 phase1 length", n, 1);
    count_in(3'b110, n); chk("R6 phase2 length", n, 2);
    count_in(3'b111, n); chk("R6 phase3 length", n, 4);
    repeat (5) step();
    chk("R6 terminal held", 32'(state_o), 32'h3);
    chk("R11 snapshot state", 32'(snap_state_o), 32'h4);
    chk("R11 snapshot accum", 32'(snap_accum_o), 16);
    chk("R11 frozen", 32'(snap_frozen_o), 1);

    clr_i = 1; step(); clr_i = 0;
    chk("R8 clear state", 32'(state_o), 0);
    chk("R8 clear accum", 32'(accum_cnt_o), 0);
    chk("R11 released", 32'(snap_frozen_o), 0);

    // R7 remap
    accum_thresh_i = 0; phase_cyc_i = '0; esc_en_i = 4'b0110;
    for (int i = 0; i < 4; i++) esc_map_i[i] = 2'b01;
    trig_i = 1; step(); trig_i = 0;
    chk("R7 remap phase0", 32'(esc_o), 0);
    step();
    chk("R7 remap phase1", 32'(esc_o), 32'h6);
    clr_i = 1; step(); clr_i = 0;
    defaults();

    // R8 clear beats trigger
    trig_i = 4'hF; clr_i = 1; step(); trig_i = 0; clr_i = 0;
    chk("R8 clear wins accum", 32'(accum_cnt_o), 0);
    chk("R8 clear wins state", 32'(state_o), 0);

    // R10 disabled
    en_i = 0; trig_i = 4'hF; irq_pend_i = 1; timeout_cyc_i = 3;
    repeat (5) step();
    chk("R10 disabled state", 32'(state_o), 0);
    chk("R10 disabled accum", 32'(accum_cnt_o), 0);
    trig_i = 0; irq_pend_i = 0; en_i = 1; step();

    // R4 timeout
    timeout_cyc_i = 5; irq_pend_i = 1; step();
    chk("R4 enter timeout", 32'(state_o), 32'h1);
    chk("R4 first count", esc_cnt_o, 1);
    n = 1;
    while (state_o != 3'b100 && n < 100) begin step(); n++; end
    chk("R4 timeout edges", n, 6);
    clr_i = 1; irq_pend_i = 0; step(); clr_i = 0;

    // R5 deassert and zero timeout
    timeout_cyc_i = 10; irq_pend_i = 1;
    repeat (4) step();
    chk("R5 counting", esc_cnt_o, 4);
    irq_pend_i = 0; step();
    chk("R5 drop state", 32'(state_o), 0);
    chk("R5 drop count", esc_cnt_o, 0);
    timeout_cyc_i = 0; irq_pend_i = 1; repeat (5) step();
    chk("R5 zero disables", 32'(state_o), 0);
    irq_pend_i = 0;

    // R9 lock
    lock_i = 1; for (int i = 0; i < 4; i++) phase_cyc_i[i] = 50;
    trig_i = 1; step(); trig_i = 0;
    chk("R9 escalated", 32'(state_o), 32'h4);
    clr_i = 1; step(); clr_i = 0;
    chk("R9 clear refused", 32'(state_o[2]), 1);
    chk("R9 accum kept", 32'(accum_cnt_o), 1);
    do_reset(); lock_i = 0;
    trig_i = 1; step(); trig_i = 0;
    clr_i = 1; step(); clr_i = 0;
    chk("R9 reset unlocks", 32'(state_o), 0);

    // R2 saturation
    do_reset(); defaults();
    accum_thresh_i = 16'hFFFF; trig_i = 1;
    repeat (65535) step();
    chk("R2 at max", 32'(accum_cnt_o), 32'hFFFF);
    chk("R3 not fired at max-1", 32'(state_o), 0);
    step();
    chk("R3 fires after max", 32'(state_o), 32'h4);
    repeat (5) step();
    chk("R2 saturated", 32'(accum_cnt_o), 32'hFFFF);
    trig_i = 0;

    // constrained random against model
    void'($urandom(32'h5EED_0042));
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(); defaults();
      accum_thresh_i = 16'($urandom % 6);
      timeout_cyc_i  = $urandom % 25;
      for (int i = 0; i < 4; i++) begin
        phase_cyc_i[i] = $urandom % 7;
        esc_map_i[i]   = 2'($urandom);
      end
      esc_en_i = 4'($urandom);
      lock_i   = 1'($urandom);
      for (int c = 0; c < 1500; c++) begin
        trig_i = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
        clr_i  = ($urandom % 97 == 0);
        if ($urandom % 40 == 0)  irq_pend_i = ~irq_pend_i;
        if ($urandom % 200 == 0) en_i = ~en_i;
        step();
      end
    end

    summary();
    $finish;
  end
endmodule